// File: doc/BRIEF.md
# Serial Byte Memory Slave

This block is the slave side of a four-wire serial link in front of a 2048-byte memory held in an on-chip register array. A host pulls chip select low, clocks in an 8-bit command, and for memory commands two address bytes. It then streams data bytes in or out, and the address steps forward after every byte. An 8-bit status register carries a write-enable latch, two block-protect bits and a protect-enable bit. The serial clock is mode 0: it idles low, input is taken on the rising edge and output moves on the falling edge.

All pins are brought into a system clock domain through a synchronizer chain. Edges of the serial clock and chip select are found by comparing the synchronized level with its previous value. A hold input freezes a transfer at any bit and lets it resume later with nothing lost. A write-protect pin can lock the status register. Memory writes are never affected by that pin.

Top module: `spi_mem_slave`

## Requirements
- R1: While chip select is high, `so_oe` is 0, the block is idle, and serial clock and serial-in activity have no effect on memory or status.
- R2: A command is only decoded as the first byte after a falling edge of chip select. Further bytes after a completed single-byte command in the same selection are ignored.
- R3: Serial-in is sampled only on rising serial-clock edges. Every byte is transferred most significant bit first.
- R4: Serial-out changes only after a falling serial-clock edge. `so_oe` is 1 only while read data or status is being shifted out.
- R5: While hold is low, serial-clock and chip-select edges are ignored, `so_oe` is 0, and the transfer state is kept. After hold returns high the transfer continues from the same bit.
- R6: While status bit 7 is 1 and the write-protect pin is low, status writes are blocked. Memory writes still work, and with status bit 7 at 0 the pin has no effect.
- R7: The opcodes are 0x06 set write latch, 0x04 clear write latch, 0x05 read status, 0x01 write status, 0x03 read memory and 0x02 write memory. Any other opcode makes the rest of the selection ignored.
- R8: Memory commands take a high and then a low address byte, and only the low 11 bits are used. The address rises by one after each data byte and wraps from 0x7FF to 0x000.
- R9: Memory and status writes happen only while the write latch is set. The latch is cleared by 0x04, and also when chip select rises after a 0x02 or 0x01 command.
- R10: The status layout is: bit 7 protect-enable, bits 3:2 block-protect (both writable), bit 1 write latch (read-only), and all other bits read 0.
- R11: A byte cut short by chip select rising is discarded and never written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, mode 0 |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Hold, active low, changed only while sck is low |
| wp_n | input | 1 | Write-protect pin for the status register, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so; 0 means tri-stated |

## Verification
The hardest condition to reach is a hold that lands in the middle of a byte while the serial clock keeps toggling. The stimulus shifts three bits of a read byte and lowers hold with the clock low. It then pulses the clock several times with serial-in changing, releases hold, and finishes the byte, so the assembled byte shows whether any held edge slipped through. The same pause is applied inside a write byte, and the stored value is read back afterwards.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
   localparam logic [7:0] OP_WREN = 8'h06;
   localparam logic [7:0] OP_WRDI = 8'h04;
   localparam logic [7:0] OP_RDSR = 8'h05;
   localparam logic [7:0] OP_WRSR = 8'h01;
   localparam logic [7:0] OP_READ = 8'h03;
   localparam logic [7:0] OP_WRIT = 8'h02;

   typedef enum logic [2:0] {
      ST_IDLE, ST_OPC, ST_ADDR, ST_WDATA, ST_RDATA, ST_RDSR, ST_WRSR, ST_SKIP
   } st_e;
endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
   parameter int          W       = 5,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_ff
         logic [W-1:0] pipe [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int k = 0; k < STAGES; k++) pipe[k] <= RST_VAL;
            end else begin
               pipe[0] <= d;
               for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
            end
         end
         assign q = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;
   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end
   assign rdata = cells[raddr];
endmodule

// File: rtl/spi_mem_status.sv
module spi_mem_status (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wp_s,
   input  logic       wel_set,
   input  logic       wel_clr,
   input  logic       wr_req,
   input  logic [7:0] wdata,
   output logic [7:0] sr,
   output logic       locked
);
   logic       wpen;
   logic [1:0] bp;
   logic       wel;

   assign locked = wpen & ~wp_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wpen <= 1'b0;
         bp   <= 2'b00;
         wel  <= 1'b0;
      end else begin
         if (wr_req && wel && !locked) begin
            wpen <= wdata[7];
            bp   <= wdata[3:2];
         end
         if (wel_clr)      wel <= 1'b0;
         else if (wel_set) wel <= 1'b1;
      end
   end

   assign sr = {wpen, 3'b000, bp, wel, 1'b0};
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
   import spi_mem_pkg::*;
#(
   parameter int ADDR_W      = 11,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sck,
   input  logic si,
   input  logic hold_n,
   input  logic wp_n,
   output logic so,
   output logic so_oe
);
   localparam int HI_W = ADDR_W - 8;

   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr
         $error("ADDR_W must lie in 9..16 to fit two address bytes");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic [4:0] pins_s;
   logic cs_s, sck_s, si_s, hold_s, wp_s;

   spi_mem_sync #(.W(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b11001)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({wp_n, hold_n, si, sck, cs_n}),
      .q(pins_s)
   );
   assign {wp_s, hold_s, si_s, sck_s, cs_s} = pins_s;

   st_e               state;
   logic              cs_int, sck_q;
   logic [2:0]        bitcnt, obit;
   logic [6:0]        sh, osh;
   logic [ADDR_W-1:0] addr;
   logic              abyte, is_rd, wr_cmd, drv, so_r;

   logic cs_fall, cs_rise, sck_rise, sck_fall, byte_done;
   logic [7:0] byte_in, rd_data, mem_rdata, sr;
   logic mem_we, sr_we, wel_set, wel_clr, locked;

   assign cs_fall   = hold_s &  ~cs_s &  cs_int;
   assign cs_rise   = hold_s &   cs_s & ~cs_int;
   assign sck_rise  = hold_s & ~cs_int &  sck_s & ~sck_q;
   assign sck_fall  = hold_s & ~cs_int & ~sck_s &  sck_q;
   assign byte_in   = {sh, si_s};
   assign byte_done = sck_rise && (state != ST_IDLE) && (bitcnt == 3'd7);

   assign mem_we  = byte_done && (state == ST_WDATA) && sr[1];
   assign sr_we   = byte_done && (state == ST_WRSR);
   assign wel_set = byte_done && (state == ST_OPC) && (byte_in == OP_WREN);
   assign wel_clr = (byte_done && (state == ST_OPC) && (byte_in == OP_WRDI))
                  || (cs_rise && wr_cmd);
   assign rd_data = (state == ST_RDSR) ? sr : mem_rdata;

   spi_mem_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
      .clk(clk), .we(mem_we), .waddr(addr), .wdata(byte_in),
      .raddr(addr), .rdata(mem_rdata)
   );

   spi_mem_status u_status (
      .clk(clk), .rst_n(rst_n), .wp_s(wp_s),
      .wel_set(wel_set), .wel_clr(wel_clr), .wr_req(sr_we),
      .wdata(byte_in), .sr(sr), .locked(locked)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cs_int <= 1'b1;
         sck_q  <= 1'b0;
         bitcnt <= '0;
         obit   <= '0;
         sh     <= '0;
         osh    <= '0;
         addr   <= '0;
         abyte  <= 1'b0;
         is_rd  <= 1'b0;
         wr_cmd <= 1'b0;
         drv    <= 1'b0;
         so_r   <= 1'b0;
      end else begin
         sck_q <= sck_s;
         if (hold_s) cs_int <= cs_s;

         if (cs_rise) begin
            state <= ST_IDLE;
            drv   <= 1'b0;
         end else if (cs_fall) begin
            state  <= ST_OPC;
            bitcnt <= '0;
            wr_cmd <= 1'b0;
            drv    <= 1'b0;
         end else if (sck_rise && state != ST_IDLE) begin
            sh     <= byte_in[6:0];
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
               unique case (state)
                  ST_OPC: begin
                     obit  <= '0;
                     abyte <= 1'b0;
                     if (byte_in == OP_READ) begin
                        is_rd <= 1'b1; state <= ST_ADDR;
                     end else if (byte_in == OP_WRIT) begin
                        is_rd <= 1'b0; wr_cmd <= 1'b1; state <= ST_ADDR;
                     end else if (byte_in == OP_WRSR) begin
                        wr_cmd <= 1'b1; state <= ST_WRSR;
                     end else if (byte_in == OP_RDSR) begin
                        state <= ST_RDSR;
                     end else begin
                        state <= ST_SKIP;
                     end
                  end
                  ST_ADDR: begin
                     if (!abyte) begin
                        addr[ADDR_W-1:8] <= byte_in[HI_W-1:0];
                        abyte <= 1'b1;
                     end else begin
                        addr[7:0] <= byte_in;
                        obit      <= '0;
                        state     <= is_rd ? ST_RDATA : ST_WDATA;
                     end
                  end
                  ST_WDATA: addr  <= addr + 1'b1;
                  ST_WRSR:  state <= ST_SKIP;
                  default:  ;
               endcase
            end
         end else if (sck_fall && (state == ST_RDATA || state == ST_RDSR)) begin
            drv  <= 1'b1;
            obit <= obit + 3'd1;
            if (obit == 3'd0) begin
               so_r <= rd_data[7];
               osh  <= rd_data[6:0];
            end else begin
               so_r <= osh[6];
               osh  <= {osh[5:0], 1'b0};
            end
            if (obit == 3'd7 && state == ST_RDATA) addr <= addr + 1'b1;
         end
      end
   end

   assign so    = so_r;
   assign so_oe = drv & hold_s & ~cs_int;
endmodule

// File: rtl/spi_mem_chk.sv
module spi_mem_chk
   import spi_mem_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       cs_int,
   input logic       hold_s,
   input logic       sck_rise,
   input logic       sck_fall,
   input logic       cs_fall,
   input logic       cs_rise,
   input logic       wr_cmd,
   input logic       locked,
   input logic       so_r,
   input logic       so_oe,
   input logic [2:0] bitcnt,
   input st_e        state,
   input logic [7:0] sr
);
   AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      cs_int |-> (state == ST_IDLE && !so_oe)); // R1
   AST_RX_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (!sck_rise && !cs_fall) |=> $stable(bitcnt)); // R3
   AST_TX_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !sck_fall |=> $stable(so_r)); // R4
   AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      !hold_s |=> ($stable(state) && $stable(bitcnt))); // R5
   AST_STATUS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable({sr[7], sr[3:2]})); // R6
   AST_WEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_rise && wr_cmd) |=> !sr[1]); // R9
endmodule

bind spi_mem_slave spi_mem_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cs_int(cs_int), .hold_s(hold_s),
   .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_fall(cs_fall),
   .cs_rise(cs_rise), .wr_cmd(wr_cmd), .locked(locked), .so_r(so_r),
   .so_oe(so_oe), .bitcnt(bitcnt), .state(state), .sr(sr)
);

// File: tb/tb_spi_mem_slave.sv
`timescale 1ns/1ps
module tb_spi_mem_slave;
   localparam int H = 8;
   localparam int NV = 8;
   localparam logic [18:0] VEC [NV] = '{
      {11'h001, 8'hA5}, {11'h0FF, 8'h3C}, {11'h100, 8'hC3}, {11'h2AA, 8'h01},
      {11'h555, 8'h80}, {11'h400, 8'hFF}, {11'h3FF, 8'h00}, {11'h7FD, 8'h7E}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
   logic so, so_oe;
   int n_chk = 0, n_fail = 0;
   logic oe_all, oe_any;

   always #2.5 clk = ~clk;

   spi_mem_slave dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
      .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_oe(so_oe)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_bit(input logic tb, output logic rb);
      sck = 1'b0; si = tb; wclk(H);
      rb = so; oe_all &= so_oe; oe_any |= so_oe;
      sck = 1'b1; wclk(H/2);
      si = ~tb; wclk(H/2);
   endtask

   task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
      oe_all = 1'b1; oe_any = 1'b0;
      for (int i = 7; i >= 0; i--) do_bit(tx[i], rx[i]);
   endtask

   task automatic sel();
      cs_n = 1'b0; wclk(H);
   endtask

   task automatic desel();
      sck = 1'b0; wclk(H); cs_n = 1'b1; wclk(H);
   endtask

   task automatic cmd1(input logic [7:0] op);
      logic [7:0] d;
      sel(); xbyte(op, d); desel();
   endtask

   task automatic wr_byte(input logic [15:0] a, input logic [7:0] v);
      logic [7:0] d;
      sel(); xbyte(8'h02, d); xbyte(a[15:8], d); xbyte(a[7:0], d); xbyte(v, d); desel();
   endtask

   task automatic rd_byte(input logic [15:0] a, output logic [7:0] v);
      logic [7:0] d;
      sel(); xbyte(8'h03, d); xbyte(a[15:8], d); xbyte(a[7:0], d); xbyte(8'h00, v); desel();
   endtask

   task automatic rdsr(output logic [7:0] v);
      logic [7:0] d;
      sel(); xbyte(8'h05, d); xbyte(8'h00, v); desel();
   endtask

   task automatic wrsr(input logic [7:0] v);
      logic [7:0] d;
      cmd1(8'h06);
      sel(); xbyte(8'h01, d); xbyte(v, d); desel();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] v, d;
      logic [15:0] a;
      logic b;
      wclk(10); rst_n = 1'b1; wclk(10);
      chk(so_oe == 1'b0, "R1 reset oe", so_oe, 0);
      rdsr(v);
      chk(v == 8'h00, "R10 status after reset", v, 8'h00);

      // R3 R8 R9: vector table write then read back
      for (int k = 0; k < NV; k++) begin
         cmd1(8'h06);
         wr_byte({5'b0, VEC[k][18:8]}, VEC[k][7:0]);
         chk(oe_any == 1'b0, "R4 oe low in write data", oe_any, 0);
      end
      rdsr(v);
      chk(v == 8'h00, "R9 latch cleared after write", v, 8'h00);
      for (int k = 0; k < NV; k++) begin
         rd_byte({5'b0, VEC[k][18:8]}, v);
         chk(v == VEC[k][7:0], "R3 table readback", v, VEC[k][7:0]);
         chk(oe_all == 1'b1, "R4 oe high in read data", oe_all, 1);
      end

      // R9: write without latch
      wr_byte(16'h0001, 8'h11);
      rd_byte(16'h0001, v);
      chk(v == 8'hA5, "R9 write without latch", v, 8'hA5);

      // R1: clock activity while deselected
      for (int i = 0; i < 16; i++) begin
         si = 1'b1; sck = 1'b1; wclk(H);
         chk(so_oe == 1'b0, "R1 oe while deselected", so_oe, 0);
         sck = 1'b0; wclk(H);
      end
      rdsr(v);
      chk(v == 8'h00, "R1 status untouched when deselected", v, 8'h00);

      // R7: unknown opcode swallows the selection
      sel(); xbyte(8'hAB, d); xbyte(8'h06, d); xbyte(8'h05, d); xbyte(8'h00, d);
      chk(oe_any == 1'b0, "R7 no output after unknown opcode", oe_any, 0);
      desel();
      rdsr(v);
      chk(v == 8'h00, "R7 latch not set after unknown opcode", v, 8'h00);

      // R2: second command in one selection ignored
      sel(); xbyte(8'h06, d); xbyte(8'h02, d); xbyte(8'h00, d); xbyte(8'h01, d); xbyte(8'h99, d); desel();
      rd_byte(16'h0001, v);
      chk(v == 8'hA5, "R2 no write without fresh select", v, 8'hA5);
      rdsr(v);
      chk(v == 8'h02, "R2 R10 latch visible in bit 1", v, 8'h02);
      cmd1(8'h04);
      rdsr(v);
      chk(v == 8'h00, "R7 clear-latch opcode", v, 8'h00);

      // R8: burst write across the wrap point, burst read back
      cmd1(8'h06);
      sel(); xbyte(8'h07, d); 
      desel();
      cmd1(8'h06);
      sel(); xbyte(8'h02, d); xbyte(8'h07, d); xbyte(8'hFE, d);
      xbyte(8'h11, d); xbyte(8'h22, d); xbyte(8'h33, d); desel();
      sel(); xbyte(8'h03, d); xbyte(8'h07, d); xbyte(8'hFE, d);
      xbyte(8'h00, v); chk(v == 8'h11, "R8 burst byte at 0x7FE", v, 8'h11);
      xbyte(8'h00, v); chk(v == 8'h22, "R8 burst byte at 0x7FF", v, 8'h22);
      xbyte(8'h00, v); chk(v == 8'h33, "R8 wrap to 0x000", v, 8'h33);
      desel();
      rd_byte(16'hFFFF, v);
      chk(v == 8'h22, "R8 upper address bits ignored", v, 8'h22);

      // R11: partial byte discarded
      cmd1(8'h06);
      sel(); xbyte(8'h02, d); xbyte(8'h00, d); xbyte(8'h01, d);
      for (int i = 0; i < 4; i++) do_bit(1'b0, b);
      desel();
      rd_byte(16'h0001, v);
      chk(v == 8'hA5, "R11 partial byte not written", v, 8'hA5);

      // R10 R6: status writes and protection
      wrsr(8'h8E);
      rdsr(v);
      chk(v == 8'h8C, "R10 writable bits and read-only latch", v, 8'h8C);
      wp_n = 1'b0;
      wrsr(8'h00);
      rdsr(v);
      chk(v == 8'h8C, "R6 status locked", v, 8'h8C);
      cmd1(8'h06);
      wr_byte(16'h0555, 8'h66);
      rd_byte(16'h0555, v);
      chk(v == 8'h66, "R6 array writable while pin low", v, 8'h66);
      wp_n = 1'b1;
      wrsr(8'h00);
      rdsr(v);
      chk(v == 8'h00, "R6 unlocked after pin high", v, 8'h00);
      wp_n = 1'b0;
      wrsr(8'h0C);
      rdsr(v);
      chk(v == 8'h0C, "R6 pin ignored while bit 7 clear", v, 8'h0C);
      wp_n = 1'b1;

      // R5: hold inside a read byte
      sel(); xbyte(8'h03, d); xbyte(8'h01, d); xbyte(8'h00, d);
      oe_all = 1'b1; oe_any = 1'b0;
      for (int i = 7; i >= 5; i--) begin do_bit(1'b0, b); v[i] = b; end
      sck = 1'b0; wclk(H);
      hold_n = 1'b0; wclk(H);
      chk(so_oe == 1'b0, "R5 oe low while held", so_oe, 0);
      for (int i = 0; i < 3; i++) begin
         sck = 1'b1; si = i[0]; wclk(H); sck = 1'b0; wclk(H);
      end
      hold_n = 1'b1; wclk(H);
      chk(so_oe == 1'b1, "R5 oe back after hold", so_oe, 1);
      for (int i = 4; i >= 0; i--) begin do_bit(1'b0, b); v[i] = b; end
      desel();
      chk(v == 8'hC3, "R5 read resumes after hold", v, 8'hC3);

      // R5: hold inside a write byte
      cmd1(8'h06);
      a = 16'h02AA;
      sel(); xbyte(8'h02, d); xbyte(a[15:8], d); xbyte(a[7:0], d);
      d = 8'h5B;
      for (int i = 7; i >= 5; i--) do_bit(d[i], b);
      sck = 1'b0; wclk(H);
      hold_n = 1'b0; wclk(H);
      for (int i = 0; i < 3; i++) begin
         si = ~si; sck = 1'b1; wclk(H); sck = 1'b0; wclk(H);
      end
      hold_n = 1'b1; wclk(H);
      for (int i = 4; i >= 0; i--) do_bit(d[i], b);
      desel();
      rd_byte(a, v);
      chk(v == 8'h5B, "R5 write resumes after hold", v, 8'h5B);
      chk(so_oe == 1'b0, "R1 oe low at end", so_oe, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule